// File: doc/BRIEF.md
# Double-Buffered Byte Serializer/Deserializer

This block turns bytes written over a register-style host port into a continuous serial bit stream, and collects a serial bit stream back into bytes. On the transmit side a holding register sits in front of a shift register. The host can write the next byte while the current one is still going out, so consecutive bytes leave with no idle bit between them. On the receive side incoming bits are shifted in. Each completed byte is copied into a data register that the host may read at any time. That register is simply replaced when the following byte completes.

Bits move one per cycle in which the bit-clock enable is high, most significant bit first. Status flags report that the holding register is free, that transmission has run dry, that a received byte is waiting, and that a waiting byte was lost. A bypass mode, present when the `BYPASS_EN` parameter is set, routes raw bits straight between the serial pins and a pair of data-only bit ports. While it is active, both framing engines stay frozen.

Top module: `byte_serdes`

## Requirements
- R1: In reset and directly after it, `ser_out` is 0, `tx_empty` is 1, and `tx_done`, `rx_ready` and `rx_overrun` are 0.
- R2: A byte written while the shifter is idle moves into the shifter one clock after the write. Its MSB appears on `ser_out` at once, and each cycle with `bit_en` high advances `ser_out` by one bit toward the LSB.
- R3: A byte waiting in the holding register when the shifter sends its last bit is loaded on that same `bit_en` edge. Its MSB follows the previous LSB with no gap.
- R4: `tx_empty` goes low in the cycle after `wr_en` and returns high once the holding register has been moved into the shifter.
- R5: When the shifter finishes a byte and the holding register is empty, `tx_done` rises and `ser_out` idles at 0. A write clears `tx_done`.
- R6: `ser_in` is sampled on each `bit_en` edge with the first bit as MSB. After the DATA_W-th such bit, `rd_data` holds the assembled byte.
- R7: `rx_ready` sets when a received byte completes and clears on the edge where `rd_en` is high.
- R8: A byte that completes while `rx_ready` is set and `rd_en` is low replaces `rd_data` and sets `rx_overrun`. `rx_overrun` clears on a read.
- R9: With `bypass` high, `ser_out` equals `byp_tx_in` and `byp_rx_out` equals `ser_in`. `bit_en` pulses during bypass do not advance receive framing, so after bypass ends a byte needs exactly DATA_W more bits. With `bypass` low, `byp_rx_out` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bypass | input | 1 | Select raw bit path instead of byte framing |
| bit_en | input | 1 | Bit-clock enable, one serial bit per high cycle |
| wr_en | input | 1 | Write `wr_data` into transmit holding register |
| wr_data | input | DATA_W | Byte to transmit |
| rd_en | input | 1 | Host read of received byte (clears ready) |
| rd_data | output | DATA_W | Last completed received byte |
| ser_in | input | 1 | Serial receive bit |
| ser_out | output | 1 | Serial transmit bit |
| byp_tx_in | input | 1 | Raw transmit bit in bypass |
| byp_rx_out | output | 1 | Raw receive bit in bypass |
| tx_empty | output | 1 | Holding register free |
| tx_done | output | 1 | Shifter finished with nothing queued |
| rx_ready | output | 1 | Unread received byte available |
| rx_overrun | output | 1 | A received byte was overwritten unread |

## Verification
A wrong bit counter in either engine shows within one byte time. On transmit it appears as a misplaced MSB of the following byte on `ser_out`, or as a `tx_done` at the wrong edge. On receive it appears as `rx_ready` rising one bit early or late, with a rotated `rd_data`. A holding register that fails to hand over shows up as a missing or idle-low bit between back-to-back bytes, on the very edge after the last bit. Stale ready or overrun state appears at the next completed byte, because the flags change when they should not.

// File: rtl/serdes_pkg.sv
package serdes_pkg;
   // receive status pair carried from the deserializer to the top
   typedef struct packed {
      logic ready;
      logic overrun;
   } rx_flags_t;
endpackage

// File: rtl/serdes_tx.sv
module serdes_tx #(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              adv,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wr_data,
   output logic              ser_bit,
   output logic              tx_empty,
   output logic              tx_done
);
   localparam int CNT_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
   localparam logic [CNT_W-1:0] LAST = CNT_W'(DATA_W - 1);

   logic [DATA_W-1:0] hold_q, sh_q;
   logic              hold_full_q, busy_q, done_q;
   logic [CNT_W-1:0]  cnt_q;
   logic              last_bit, take;

   assign last_bit = busy_q && adv && (cnt_q == LAST);
   assign take     = hold_full_q && (!busy_q || last_bit);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         hold_q      <= '0;
         sh_q        <= '0;
         hold_full_q <= 1'b0;
         busy_q      <= 1'b0;
         done_q      <= 1'b0;
         cnt_q       <= '0;
      end else begin
         if (take) begin
            sh_q   <= hold_q;
            busy_q <= 1'b1;
            cnt_q  <= '0;
         end else if (busy_q && adv) begin
            if (last_bit) begin
               busy_q <= 1'b0;
               cnt_q  <= '0;
            end else begin
               sh_q  <= {sh_q[DATA_W-2:0], 1'b0};
               cnt_q <= cnt_q + 1'b1;
            end
         end
         hold_full_q <= wr_en | (hold_full_q & ~take);
         if (wr_en) hold_q <= wr_data;
         if (wr_en)                          done_q <= 1'b0;
         else if (last_bit && !hold_full_q)  done_q <= 1'b1;
      end
   end

   assign ser_bit  = busy_q & sh_q[DATA_W-1];
   assign tx_empty = ~hold_full_q;
   assign tx_done  = done_q;

   // R4: a write always leaves the holding register occupied next cycle
   a_r4_full_after_write: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> !tx_empty);
   // R3: queued byte keeps the shifter running across the byte boundary
   a_r3_no_gap: assert property (@(posedge clk) disable iff (!rst_n)
      (last_bit && hold_full_q) |=> busy_q);
   // R5: the done flag is never up while a byte is shifting
   a_r5_done_means_idle: assert property (@(posedge clk) disable iff (!rst_n)
      done_q |-> !busy_q);
endmodule

// File: rtl/serdes_rx.sv
module serdes_rx
   import serdes_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              adv,
   input  logic              ser_in,
   input  logic              rd_en,
   output logic [DATA_W-1:0] rd_data,
   output rx_flags_t         flags
);
   localparam int CNT_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
   localparam logic [CNT_W-1:0] LAST = CNT_W'(DATA_W - 1);

   logic [DATA_W-1:0] sh_q, data_q;
   logic [CNT_W-1:0]  cnt_q;
   logic              ready_q, ovr_q, complete;
   logic [DATA_W-1:0] next_sh;

   assign next_sh  = {sh_q[DATA_W-2:0], ser_in};
   assign complete = adv && (cnt_q == LAST);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sh_q    <= '0;
         data_q  <= '0;
         cnt_q   <= '0;
         ready_q <= 1'b0;
         ovr_q   <= 1'b0;
      end else begin
         if (adv) begin
            sh_q  <= next_sh;
            cnt_q <= complete ? '0 : cnt_q + 1'b1;
         end
         if (complete) data_q <= next_sh;
         if (complete)   ready_q <= 1'b1;
         else if (rd_en) ready_q <= 1'b0;
         if (complete && ready_q && !rd_en) ovr_q <= 1'b1;
         else if (rd_en)                    ovr_q <= 1'b0;
      end
   end

   assign rd_data       = data_q;
   assign flags.ready   = ready_q;
   assign flags.overrun = ovr_q;

   // R7: a finished byte always announces itself
   a_r7_ready_on_byte: assert property (@(posedge clk) disable iff (!rst_n)
      complete |=> flags.ready);
   // R8: an unread byte overwritten raises overrun
   a_r8_overrun_set: assert property (@(posedge clk) disable iff (!rst_n)
      (complete && ready_q && !rd_en) |=> flags.overrun);
   // R9: framing position frozen while not advancing (bypass or no bit)
   a_r9_hold_when_stalled: assert property (@(posedge clk) disable iff (!rst_n)
      !adv |=> $stable(cnt_q));
endmodule

// File: rtl/byte_serdes.sv
module byte_serdes
   import serdes_pkg::*;
#(
   parameter int DATA_W    = 8,
   parameter bit BYPASS_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bypass,
   input  logic              bit_en,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              rd_en,
   output logic [DATA_W-1:0] rd_data,
   input  logic              ser_in,
   output logic              ser_out,
   input  logic              byp_tx_in,
   output logic              byp_rx_out,
   output logic              tx_empty,
   output logic              tx_done,
   output logic              rx_ready,
   output logic              rx_overrun
);
   if (DATA_W < 2) begin : g_bad_width
      $error("byte_serdes: DATA_W must be at least 2");
   end

   logic      byp_on, adv, tx_bit;
   rx_flags_t rx_flags;

   if (BYPASS_EN) begin : g_byp
      assign byp_on     = bypass;
      assign ser_out    = bypass ? byp_tx_in : tx_bit;
      assign byp_rx_out = bypass & ser_in;
   end else begin : g_no_byp
      logic unused_byp;
      assign unused_byp = bypass ^ byp_tx_in;
      assign byp_on     = 1'b0;
      assign ser_out    = tx_bit;
      assign byp_rx_out = 1'b0;
   end

   assign adv = bit_en & ~byp_on;

   serdes_tx #(.DATA_W(DATA_W)) u_tx (
      .clk      (clk),
      .rst_n    (rst_n),
      .adv      (adv),
      .wr_en    (wr_en),
      .wr_data  (wr_data),
      .ser_bit  (tx_bit),
      .tx_empty (tx_empty),
      .tx_done  (tx_done)
   );

   serdes_rx #(.DATA_W(DATA_W)) u_rx (
      .clk     (clk),
      .rst_n   (rst_n),
      .adv     (adv),
      .ser_in  (ser_in),
      .rd_en   (rd_en),
      .rd_data (rd_data),
      .flags   (rx_flags)
   );

   assign rx_ready   = rx_flags.ready;
   assign rx_overrun = rx_flags.overrun;

   // R1: outputs quiet while reset is held
   a_r1_reset_quiet: assert property (@(posedge clk)
      !rst_n |=> (!rx_ready && !rx_overrun && !tx_done && tx_empty));
   // R9: bypass routes the raw bit to the serial pin
   a_r9_bypass_route: assert property (@(posedge clk) disable iff (!rst_n)
      (BYPASS_EN && bypass) |-> (ser_out == byp_tx_in));
endmodule

// File: tb/sim_byte_serdes.sv
module sim_byte_serdes;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       bypass = 1'b0, bit_en = 1'b0, wr_en = 1'b0, rd_en = 1'b0;
   logic [7:0] wr_data = '0;
   logic       ser_in = 1'b0, byp_tx_in = 1'b0;
   logic [7:0] rd_data;
   logic       ser_out, byp_rx_out, tx_empty, tx_done, rx_ready, rx_overrun;
   int         checks = 0, errors = 0;
   bit         finished = 1'b0;

   always #5 clk = ~clk;

   byte_serdes #(.DATA_W(8), .BYPASS_EN(1'b1)) u0 (
      .clk(clk), .rst_n(rst_n), .bypass(bypass), .bit_en(bit_en),
      .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en), .rd_data(rd_data),
      .ser_in(ser_in), .ser_out(ser_out), .byp_tx_in(byp_tx_in),
      .byp_rx_out(byp_rx_out), .tx_empty(tx_empty), .tx_done(tx_done),
      .rx_ready(rx_ready), .rx_overrun(rx_overrun));

   // each entry: {byte to transmit, byte to receive}
   localparam logic [15:0] VEC [4] = '{16'hA5_3C, 16'h01_80, 16'hFF_00, 16'h6E_D7};

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic cyc(input logic en, input logic w, input logic [7:0] wd,
                      input logic r, input logic si);
      @(negedge clk);
      bit_en = en; wr_en = w; wr_data = wd; rd_en = r; ser_in = si;
      @(posedge clk);
      #1;
      bit_en = 1'b0; wr_en = 1'b0; rd_en = 1'b0;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         errors++;
         $display("FAIL watchdog actual 1 expected 0");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      logic [15:0] txs, rxs;
      repeat (3) @(posedge clk);
      #1;
      chk("R1 ser_out", ser_out, 0);
      chk("R1 tx_empty", tx_empty, 1);
      chk("R1 tx_done", tx_done, 0);
      chk("R1 rx_ready", rx_ready, 0);
      chk("R1 rx_overrun", rx_overrun, 0);
      @(negedge clk); rst_n = 1'b1;
      @(posedge clk); #1;
      chk("R1 after release tx_empty", tx_empty, 1);

      // table walk: one transmit byte and one receive byte per entry
      for (int i = 0; i < 4; i++) begin
         logic [7:0] tb_tx, tb_rx;
         tb_tx = VEC[i][15:8];
         tb_rx = VEC[i][7:0];
         if (i > 0) chk("R5 done before write", tx_done, 1);
         cyc(1'b0, 1'b1, tb_tx, 1'b0, 1'b0);
         chk("R4 empty low after write", tx_empty, 0);
         chk("R5 write clears done", tx_done, 0);
         cyc(1'b0, 1'b0, 8'h00, 1'b0, 1'b0);
         chk("R4 empty after move", tx_empty, 1);
         for (int b = 7; b >= 0; b--) begin
            chk("R2 ser_out bit", ser_out, tb_tx[b]);
            cyc(1'b1, 1'b0, 8'h00, 1'b0, tb_rx[b]);
         end
         chk("R5 done raised", tx_done, 1);
         chk("R5 idle low", ser_out, 0);
         chk("R7 ready set", rx_ready, 1);
         chk("R6 rd_data", rd_data, tb_rx);
         chk("R8 no overrun", rx_overrun, 0);
         cyc(1'b0, 1'b0, 8'h00, 1'b1, 1'b0);
         chk("R7 ready cleared by read", rx_ready, 0);
      end

      // back-to-back bytes, and two received bytes with no read between
      txs = 16'hC3_5A;
      rxs = 16'h3E_B1;
      cyc(1'b0, 1'b1, txs[15:8], 1'b0, 1'b0);
      cyc(1'b0, 1'b0, 8'h00, 1'b0, 1'b0);
      cyc(1'b0, 1'b1, txs[7:0], 1'b0, 1'b0);
      chk("R4 empty low with queued byte", tx_empty, 0);
      for (int k = 15; k >= 0; k--) begin
         chk("R3 gapless stream bit", ser_out, txs[k]);
         cyc(1'b1, 1'b0, 8'h00, 1'b0, rxs[k]);
         if (k == 8) begin
            chk("R4 empty after handover", tx_empty, 1);
            chk("R3 no done at handover", tx_done, 0);
            chk("R6 first byte", rd_data, rxs[15:8]);
         end
      end
      chk("R5 done after second byte", tx_done, 1);
      chk("R8 overwritten data", rd_data, rxs[7:0]);
      chk("R8 overrun set", rx_overrun, 1);
      cyc(1'b0, 1'b0, 8'h00, 1'b1, 1'b0);
      chk("R8 overrun cleared by read", rx_overrun, 0);
      chk("R7 ready cleared", rx_ready, 0);

      // bypass path and frozen framing
      @(negedge clk);
      bypass = 1'b1; byp_tx_in = 1'b1; ser_in = 1'b1;
      #1;
      chk("R9 ser_out follows byp_tx_in", ser_out, 1);
      chk("R9 byp_rx_out follows ser_in", byp_rx_out, 1);
      byp_tx_in = 1'b0; ser_in = 1'b0;
      #1;
      chk("R9 ser_out low", ser_out, 0);
      chk("R9 byp_rx_out low", byp_rx_out, 0);
      for (int j = 0; j < 3; j++) cyc(1'b1, 1'b0, 8'h00, 1'b0, 1'b1);
      chk("R9 no byte during bypass", rx_ready, 0);
      @(negedge clk);
      bypass = 1'b0; ser_in = 1'b1;
      #1;
      chk("R9 byp_rx_out zero when off", byp_rx_out, 0);
      for (int b = 7; b >= 0; b--) begin
         logic [7:0] pat;
         pat = 8'h96;
         cyc(1'b1, 1'b0, 8'h00, 1'b0, pat[b]);
         if (b == 1) chk("R9 not ready after 7 bits", rx_ready, 0);
      end
      chk("R9 ready after 8 bits", rx_ready, 1);
      chk("R9 byte after bypass", rd_data, 8'h96);

      finished = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule